// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and walks the memory from power-on to a state in which normal traffic may begin. After reset it holds the clock enable low for a programmable stable-clock period, then raises it with a NOP. It then issues, in a fixed order: precharge-all, an extended mode register write that enables the DLL, a main mode register write that resets the DLL, a second precharge-all, a programmable number of auto-refreshes, and a final main mode register write with the DLL-reset bit cleared. Each command is followed by NOP cycles that honour its own minimum spacing.

A DLL lock counter starts on the DLL-reset write and runs in parallel with the later steps. The `init_done` flag rises only when both the lock window and the spacing after the final mode register write have run out, and stays high from then on. Mode register contents and all waits are parameters. The power-up wait is derived from a clock period in picoseconds and a duration in microseconds.

States: `ST_POWERUP` (clock enable low, counting) goes to `ST_CKE_NOP` when the count ends. `ST_CKE_NOP` goes to `ST_PRE_A`. Each command state (`ST_PRE_A`, `ST_EMRS`, `ST_MRS_DLLRST`, `ST_PRE_B`, `ST_REFRESH`) loads the gap timer and goes to `ST_GAP`. `ST_GAP` goes to the recorded next command when the timer ends: `ST_PRE_A`→`ST_EMRS`, `ST_EMRS`→`ST_MRS_DLLRST`, `ST_MRS_DLLRST`→`ST_PRE_B`, `ST_PRE_B`→`ST_REFRESH`, and `ST_REFRESH`→`ST_REFRESH` while refreshes remain, otherwise `ST_MRS_FINAL`. `ST_MRS_FINAL` goes to `ST_FINAL_WAIT`. `ST_FINAL_WAIT` goes to `ST_DONE` once the timer has ended and the lock window is over. `ST_DONE` is terminal.

Top module: `ddr_init_seq`

## Requirements
- R1: Under reset and for the power-up window after it, the clock enable is low and `init_done` is low. Once the clock enable has risen it never falls again.
- R2: A precharge-all drives chip select, row strobe and write enable low with column strobe high, and address bit 10 high, with all other address and bank bits zero. The first is issued one cycle after the clock enable rises. The second is issued tMRD cycles after the DLL-reset mode write.
- R3: The extended mode write drives all four command pins low, with bank = 01 (BA0 high). A0 = 0 enables the DLL, and A6/A1 carry the drive-strength parameter bits [1]/[0]. All other address bits are 0. It is issued tRP cycles after the first precharge-all, with the clock enable high in that cycle and the one before.
- R4: The DLL-reset mode write drives all four command pins low, with bank = 00. A2..A0 carry the burst-length code, A3 the burst type, and A6..A4 the latency code. A7 = 0, A8 = 1, and A11..A9 = 0. It is issued tMRD cycles after the extended mode write.
- R5: REF_COUNT auto-refreshes are issued, encoded as chip select, row and column strobes low with write enable high, and all address bits zero. The first comes tRP cycles after the second precharge-all, and each further one comes tRFC cycles after the previous.
- R6: The final mode write carries the same fields as in R4 but with A8 = 0. It is issued tRFC cycles after the last refresh.
- R7: `init_done` rises in cycle max(F + tMRD, L + DLL_LOCK_CLKS), where F is the cycle of the final mode write and L the cycle of the DLL-reset write. It then stays high, and it is never high before the lock window has ended.
- R8: In every cycle without a command, the pins carry a NOP: chip select low, the other three high, and address and bank zero. Every command is followed by at least one NOP.
- R9: The power-up window lasts ceil(STABLE_US·10^6 / CLK_PERIOD_PS) cycles, counted from the first cycle after reset release. The clock enable rises, with a NOP, in the cycle after the window ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all pins change after its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row address strobe, active low |
| ddr_cas_n | output | 1 | Column address strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Row/column/mode address |
| init_done | output | 1 | High once initialization is complete |

## Verification
The bench builds two instances side by side. The first uses a 20 ns period and a 1 µs power-up, which gives a 50-cycle window, with tRP 6, tRFC 20, tMRD 2, two refreshes and a 200-cycle lock, so the lock window decides when `init_done` rises. The second uses a 2 µs power-up, tRP 3, tRFC 5, tMRD 3, three refreshes, a 10-cycle lock, an 8-beat interleaved burst and both drive-strength bits set. Here the spacing after the final mode write decides completion, and each mode field is seen with non-zero values in both positions.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_CKE_NOP,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_DLLRST,
        ST_PRE_B,
        ST_REFRESH,
        ST_MRS_FINAL,
        ST_GAP,
        ST_FINAL_WAIT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        CK_NOP,
        CK_PRE_ALL,
        CK_REFRESH,
        CK_EMRS,
        CK_MRS_RST,
        CK_MRS_RUN
    } cmd_kind_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_PRE     = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_pins_t PINS_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_pins_t PINS_MODE    = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int unsigned     W         = 8,
    parameter logic [W-1:0]    RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         near_end
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= RESET_VAL;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign near_end = (remain <= W'(1));

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && remain == '0) |=> (remain == '0));
endmodule

// File: rtl/ddr_dll_lock_cnt.sv
module ddr_dll_lock_cnt #(
    parameter int unsigned LOCK_CLKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic lock_ok
);
    localparam int unsigned LW = $clog2(LOCK_CLKS + 1) + 1;
    localparam logic [LW-1:0] LAST = LW'(LOCK_CLKS - 1);

    logic          running;
    logic [LW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            elapsed <= '0;
        end else if (start) begin
            running <= 1'b1;
            elapsed <= LW'(1);
        end else if (running && elapsed < LAST) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    assign lock_ok = running && (elapsed >= LAST);

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_ok && !start) |=> lock_ok);
endmodule

// File: rtl/ddr_cmd_encoder.sv
module ddr_cmd_encoder
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned BA_W    = 2,
    parameter logic [2:0]  MR_BL   = 3'b010,
    parameter logic        MR_BT   = 1'b0,
    parameter logic [2:0]  MR_CL   = 3'b011,
    parameter logic [1:0]  EMR_DRV = 2'b00
) (
    input  cmd_kind_e          kind,
    input  logic               cke_en,
    output logic               cke,
    output cmd_pins_t          pins,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr
);
    localparam int unsigned AP_BIT  = 10;
    localparam int unsigned DLL_BIT = 8;

    assign cke = cke_en;

    always_comb begin
        pins = PINS_NOP;
        ba   = '0;
        addr = '0;
        unique case (kind)
            CK_NOP: ;
            CK_PRE_ALL: begin
                pins         = PINS_PRE;
                addr[AP_BIT] = 1'b1;
            end
            CK_REFRESH: pins = PINS_REFRESH;
            CK_EMRS: begin
                pins    = PINS_MODE;
                ba[0]   = 1'b1;
                addr[0] = 1'b0;
                addr[1] = EMR_DRV[0];
                addr[6] = EMR_DRV[1];
            end
            CK_MRS_RST, CK_MRS_RUN: begin
                pins          = PINS_MODE;
                addr[2:0]     = MR_BL;
                addr[3]       = MR_BT;
                addr[6:4]     = MR_CL;
                addr[DLL_BIT] = (kind == CK_MRS_RST);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 3300,
    parameter int unsigned STABLE_US     = 200,
    parameter int unsigned T_RP          = 6,
    parameter int unsigned T_RFC         = 20,
    parameter int unsigned T_MRD         = 2,
    parameter int unsigned REF_COUNT     = 2,
    parameter int unsigned DLL_LOCK_CLKS = 200,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BA_W          = 2,
    parameter logic [2:0]  MR_BL         = 3'b010,
    parameter logic        MR_BT         = 1'b0,
    parameter logic [2:0]  MR_CL         = 3'b011,
    parameter logic [1:0]  EMR_DRV       = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);
    localparam longint unsigned PU_NUM = longint'(STABLE_US) * 64'd1000000;
    localparam int unsigned PU_CLKS =
        int'((PU_NUM + longint'(CLK_PERIOD_PS) - 1) / longint'(CLK_PERIOD_PS));
    localparam int unsigned TMR_W = $clog2(PU_CLKS + T_RP + T_RFC + T_MRD + 2);
    localparam int unsigned RW    = $clog2(REF_COUNT + 1);

    localparam logic [TMR_W-1:0] PU_LOAD  = TMR_W'(PU_CLKS);
    localparam logic [TMR_W-1:0] GAP_RP   = TMR_W'((T_RP  > 1) ? T_RP  - 1 : 1);
    localparam logic [TMR_W-1:0] GAP_RFC  = TMR_W'((T_RFC > 1) ? T_RFC - 1 : 1);
    localparam logic [TMR_W-1:0] GAP_MRD  = TMR_W'((T_MRD > 1) ? T_MRD - 1 : 1);
    localparam logic [RW-1:0]    REF_INIT = RW'(REF_COUNT);

    seq_state_e       state, state_nxt;
    seq_state_e       after_gap, after_nxt;
    logic [RW-1:0]    refs_left;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_end;
    logic             lock_start;
    logic             lock_ok;
    cmd_kind_e        kind;
    logic             cke_en;
    cmd_pins_t        pins;

    ddr_init_timer #(.W(TMR_W), .RESET_VAL(PU_LOAD)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .near_end(tmr_end)
    );

    ddr_dll_lock_cnt #(.LOCK_CLKS(DLL_LOCK_CLKS)) u_lock (
        .clk(clk), .rst_n(rst_n), .start(lock_start), .lock_ok(lock_ok)
    );

    ddr_cmd_encoder #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .MR_BL(MR_BL), .MR_BT(MR_BT),
        .MR_CL(MR_CL), .EMR_DRV(EMR_DRV)
    ) u_enc (
        .kind(kind), .cke_en(cke_en), .cke(ddr_cke), .pins(pins),
        .ba(ddr_ba), .addr(ddr_addr)
    );

    assign ddr_cs_n  = pins.cs_n;
    assign ddr_ras_n = pins.ras_n;
    assign ddr_cas_n = pins.cas_n;
    assign ddr_we_n  = pins.we_n;

    // Next state, gap target and timer loads
    always_comb begin
        state_nxt  = state;
        after_nxt  = after_gap;
        tmr_load   = 1'b0;
        tmr_val    = GAP_MRD;
        lock_start = 1'b0;
        unique case (state)
            ST_POWERUP:    if (tmr_end) state_nxt = ST_CKE_NOP;
            ST_CKE_NOP:    state_nxt = ST_PRE_A;
            ST_PRE_A: begin
                tmr_load  = 1'b1;
                tmr_val   = GAP_RP;
                after_nxt = ST_EMRS;
                state_nxt = ST_GAP;
            end
            ST_EMRS: begin
                tmr_load  = 1'b1;
                tmr_val   = GAP_MRD;
                after_nxt = ST_MRS_DLLRST;
                state_nxt = ST_GAP;
            end
            ST_MRS_DLLRST: begin
                tmr_load   = 1'b1;
                tmr_val    = GAP_MRD;
                lock_start = 1'b1;
                after_nxt  = ST_PRE_B;
                state_nxt  = ST_GAP;
            end
            ST_PRE_B: begin
                tmr_load  = 1'b1;
                tmr_val   = GAP_RP;
                after_nxt = ST_REFRESH;
                state_nxt = ST_GAP;
            end
            ST_REFRESH: begin
                tmr_load  = 1'b1;
                tmr_val   = GAP_RFC;
                after_nxt = (refs_left <= RW'(1)) ? ST_MRS_FINAL : ST_REFRESH;
                state_nxt = ST_GAP;
            end
            ST_MRS_FINAL: begin
                tmr_load  = 1'b1;
                tmr_val   = GAP_MRD;
                state_nxt = ST_FINAL_WAIT;
            end
            ST_GAP:        if (tmr_end) state_nxt = after_gap;
            ST_FINAL_WAIT: if (tmr_end && lock_ok) state_nxt = ST_DONE;
            ST_DONE:       state_nxt = ST_DONE;
            default:       state_nxt = ST_POWERUP;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            after_gap <= ST_PRE_A;
            refs_left <= REF_INIT;
        end else begin
            state     <= state_nxt;
            after_gap <= after_nxt;
            if (state == ST_REFRESH && refs_left != '0)
                refs_left <= refs_left - 1'b1;
        end
    end

    // Outputs per state
    always_comb begin
        kind      = CK_NOP;
        cke_en    = 1'b1;
        init_done = 1'b0;
        unique case (state)
            ST_POWERUP:    cke_en = 1'b0;
            ST_PRE_A,
            ST_PRE_B:      kind = CK_PRE_ALL;
            ST_EMRS:       kind = CK_EMRS;
            ST_MRS_DLLRST: kind = CK_MRS_RST;
            ST_REFRESH:    kind = CK_REFRESH;
            ST_MRS_FINAL:  kind = CK_MRS_RUN;
            ST_DONE:       init_done = 1'b1;
            default:       kind = CK_NOP;
        endcase
    end

    // R1
    cke_never_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ddr_cke));

    // R8
    cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_cs_n && !(ddr_ras_n && ddr_cas_n && ddr_we_n))
        |=> (!ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n));

    // R3
    mode_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_cs_n && !ddr_ras_n && !ddr_cas_n && !ddr_we_n)
        |-> (ddr_cke && $past(ddr_cke)));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R7
    done_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> lock_ok);
endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit comparing = 1'b0;
    bit finished = 1'b0;

    // Instance A: 50-cycle power-up, lock window dominates
    logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0] a_ba;
    logic [11:0] a_addr;
    ddr_init_seq #(
        .CLK_PERIOD_PS(20000), .STABLE_US(1), .T_RP(6), .T_RFC(20), .T_MRD(2),
        .REF_COUNT(2), .DLL_LOCK_CLKS(200)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ddr_cke(a_cke), .ddr_cs_n(a_cs),
        .ddr_ras_n(a_ras), .ddr_cas_n(a_cas), .ddr_we_n(a_we),
        .ddr_ba(a_ba), .ddr_addr(a_addr), .init_done(a_done)
    );

    // Instance B: three refreshes, short lock, final spacing dominates
    logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0] b_ba;
    logic [11:0] b_addr;
    ddr_init_seq #(
        .CLK_PERIOD_PS(20000), .STABLE_US(2), .T_RP(3), .T_RFC(5), .T_MRD(3),
        .REF_COUNT(3), .DLL_LOCK_CLKS(10), .MR_BL(3'b011), .MR_BT(1'b1),
        .MR_CL(3'b011), .EMR_DRV(2'b11)
    ) uut_b (
        .clk(clk), .rst_n(rst_n), .ddr_cke(b_cke), .ddr_cs_n(b_cs),
        .ddr_ras_n(b_ras), .ddr_cas_n(b_cas), .ddr_we_n(b_we),
        .ddr_ba(b_ba), .ddr_addr(b_addr), .init_done(b_done)
    );

    // kinds: -1 power-up, 0 NOP, 1 precharge-all, 2 ext mode, 3 DLL-reset mode,
    // 4 refresh, 5 final mode
    function automatic int kind_at(int c, int pu, int trp, int tmrd, int trfc, int nref);
        int t;
        int sched_c[$];
        int sched_k[$];
        t = pu + 1;
        sched_c.push_back(t); sched_k.push_back(1); t += trp;
        sched_c.push_back(t); sched_k.push_back(2); t += tmrd;
        sched_c.push_back(t); sched_k.push_back(3); t += tmrd;
        sched_c.push_back(t); sched_k.push_back(1); t += trp;
        for (int i = 0; i < nref; i++) begin
            sched_c.push_back(t); sched_k.push_back(4); t += trfc;
        end
        sched_c.push_back(t); sched_k.push_back(5);
        for (int i = 0; i < sched_c.size(); i++)
            if (sched_c[i] == c) return sched_k[i];
        return (c < pu) ? -1 : 0;
    endfunction

    function automatic int done_cycle(int pu, int trp, int tmrd, int trfc, int nref, int lock);
        int l, f;
        l = pu + 1 + trp + tmrd;
        f = l + tmrd + trp + nref * trfc;
        return (f + tmrd > l + lock) ? f + tmrd : l + lock;
    endfunction

    // {cs,ras,cas,we, ba[1:0], addr[11:0]}
    function automatic logic [17:0] exp_bus(int k, logic [2:0] bl, logic bt,
                                            logic [2:0] cl, logic [1:0] drv);
        case (k)
            1: return {4'b0010, 2'b00, 12'h400};
            2: return {4'b0000, 2'b01, 5'b0, drv[1], 4'b0, drv[0], 1'b0};
            3: return {4'b0000, 2'b00, 3'b000, 1'b1, 1'b0, cl, bt, bl};
            4: return {4'b0001, 2'b00, 12'h000};
            5: return {4'b0000, 2'b00, 3'b000, 1'b0, 1'b0, cl, bt, bl};
            default: return {4'b0111, 2'b00, 12'h000};
        endcase
    endfunction

    function automatic string req_of(int k);
        case (k)
            -1: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic compare(string nm, int pu, int trp, int tmrd, int trfc, int nref, int lock,
                           logic [2:0] bl, logic bt, logic [2:0] cl, logic [1:0] drv,
                           logic cke, logic cs, logic ras, logic cas, logic we,
                           logic [1:0] ba, logic [11:0] addr, logic done);
        int k;
        int d;
        logic [17:0] e;
        k = kind_at(cyc, pu, trp, tmrd, trfc, nref);
        d = done_cycle(pu, trp, tmrd, trfc, nref, lock);
        e = exp_bus(k, bl, bt, cl, drv);
        chk(cke === (cyc >= pu), (cyc == pu - 1 || cyc == pu) ? "R9" : "R1",
            {nm, " cke"}, 32'(cke), 32'(cyc >= pu));
        chk({cs, ras, cas, we} === e[17:14], req_of(k), {nm, " cmd"},
            32'({cs, ras, cas, we}), 32'(e[17:14]));
        chk({ba, addr} === e[13:0], req_of(k), {nm, " ba/addr"},
            32'({ba, addr}), 32'(e[13:0]));
        chk(done === (cyc >= d), "R7", {nm, " init_done"}, 32'(done), 32'(cyc >= d));
    endtask

    always @(posedge clk) if (rst_n) cyc++;

    always @(negedge clk) begin
        if (comparing) begin
            compare("A", 50, 6, 2, 20, 2, 200, 3'b010, 1'b0, 3'b011, 2'b00,
                    a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done);
            compare("B", 100, 3, 3, 5, 3, 10, 3'b011, 1'b1, 3'b011, 2'b11,
                    b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(a_cke === 1'b0 && b_cke === 1'b0, "R1", "cke under reset",
            32'({a_cke, b_cke}), 32'h0);
        chk(a_done === 1'b0 && b_done === 1'b0, "R1", "init_done under reset",
            32'({a_done, b_done}), 32'h0);
        rst_n = 1'b1;
        comparing = 1'b1;
        while (cyc < 320) @(negedge clk);
        comparing = 1'b0;
        @(negedge clk);
        // R7: both complete and hold
        chk(a_done === 1'b1 && b_done === 1'b1, "R7", "init_done held at end",
            32'({a_done, b_done}), 32'h3);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule